// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the processor-facing register layer of a three-channel interval timer. A host reaches it through a 2-bit port address, an 8-bit data bus and separate read and write strobes. Ports 0 to 2 are the data windows of the three channels. Port 3 takes control words. A control word picks one channel and then either programs that channel's counting mode, number format and byte access pattern, or takes a snapshot of its count.

Writes to a data window are gathered into a 16-bit initial count. The count goes to the channel's counting engine, together with a one-cycle load pulse, once the last byte that the access pattern needs has arrived. Reads return the live count of the channel, or the snapshot if one is held. In both cases the bytes come out in the order that the access pattern sets. The counting engines sit outside this block. The block only sees each engine's present count and drives the configuration and load signals to it.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel has mode 0, binary counting, the two-byte access pattern, no snapshot held and a load value of 0. No load pulse is active, and `rdata` is 0 while `rd_en` is low.
- R2: A write to port 3 programs only the channel named in data bits 7:6 (0, 1 or 2), provided data bits 5:4 are not 00. Bits 5:4 give the access pattern: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. Bits 3:1 give the mode, where 6 reads as 2 and 7 reads as 3, so the mode output never exceeds 5. Bit 0 set selects decimal (BCD) counting.
- R3: A control word with bits 7:6 equal to 11 changes no channel's mode, format, pattern or snapshot.
- R4: With the low-only pattern, a data write of byte d sets the channel's load value to {0x00, d}. The load pulse is high for exactly the cycle after the write.
- R5: With the high-only pattern, a data write of byte d sets the load value to {d, 0x00} and pulses the load.
- R6: With the two-byte pattern, the first data write neither pulses the load nor changes the load value. The second write sets the load value to {second, first} and pulses the load.
- R7: A control word with bits 5:4 equal to 00 captures the selected channel's count. Later reads return the captured bytes even if the live count moves. The command leaves mode, format and access pattern unchanged.
- R8: A capture command that arrives while an earlier snapshot is not yet fully read is ignored.
- R9: Once every byte of a snapshot has been read (one read for a single-byte pattern, two reads for the two-byte pattern), reads return the live count again.
- R10: A programming control word resets that channel's read and write byte order to the low byte and drops any held snapshot.
- R11: A data read without a snapshot returns the live count. The low-only pattern gives the low byte, the high-only pattern gives the high byte, and the two-byte pattern gives the low byte and then the high byte on alternate reads.
- R12: `rdata` is combinational. It is 0 when `rd_en` is low or when port 3 is addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Port address: 0 to 2 are channel data, 3 is control |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rd_en | input | 1 | Read strobe, one read per high cycle |
| rdata | output | 8 | Read data byte, valid while `rd_en` is high |
| live_cnt | input | 48 | Present counts of the channels, channel i in bits 16i+15:16i |
| load_val | output | 48 | Assembled initial counts, channel i in bits 16i+15:16i |
| load_stb | output | 3 | One-cycle load pulse per channel |
| ch_mode | output | 9 | Counting mode per channel, channel i in bits 3i+2:3i |
| ch_bcd | output | 3 | Decimal counting flag per channel |

## Verification
The assertions check on every cycle that a load pulse follows a data write to the same channel, that a load value moves only when its pulse fires, that no mode exceeds 5, and that mode and format outputs change only after a control write and never after one with select 11. The bench scenarios are needed to show the byte order of two-byte transfers, the freezing of a snapshot against a moving count, the ignored second capture, the return to live reads after the last snapshot byte, and the reset of byte order by a new control word.

// File: rtl/tmr_pkg.sv
// Shared types and field positions of the timer host register front end.
// Assumes an 8-bit host bus and 16-bit counts.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 3;

    // Access pattern field of a control word
    typedef enum logic [1:0] {
        FMT_SNAP = 2'b00,
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_BOTH = 2'b11
    } fmt_e;

    // Bit positions inside a control word
    localparam int SEL_MSB  = 7;
    localparam int FMT_MSB  = 5;
    localparam int MODE_MSB = 3;
    localparam int BCD_BIT  = 0;
endpackage

// File: rtl/tmr_cw_dec.sv
// Control word and port decoder.
// Turns a host write into per-channel programming, capture and data-write
// strokes, and extracts the fields of a control word.
// Assumes that port NCH is the control port and that the lower ports are channels.
module tmr_cw_dec
    import tmr_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    cw_cfg,
    output logic [NCH-1:0]    cw_snap,
    output logic [NCH-1:0]    dat_wr,
    output fmt_e              cw_fmt,
    output logic [MODE_W-1:0] cw_mode,
    output logic              cw_bcd
);
    localparam logic [ADDR_W-1:0] CTRL_PORT = ADDR_W'(NCH);

    logic [1:0]        sel;
    logic [MODE_W-1:0] mode_raw;

    // Field extraction, with modes 6 and 7 folded onto 2 and 3
    always_comb begin
        sel      = wdata[SEL_MSB -: 2];
        cw_fmt   = fmt_e'(wdata[FMT_MSB -: 2]);
        mode_raw = wdata[MODE_MSB -: MODE_W];
        cw_bcd   = wdata[BCD_BIT];
        cw_mode  = (mode_raw[2] && mode_raw[1]) ? {1'b0, mode_raw[1:0]} : mode_raw;
    end

    // Per-channel stroke decode
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cw_cfg[i]  = wr_en && (addr == CTRL_PORT) && (sel == 2'(i)) && (cw_fmt != FMT_SNAP);
            cw_snap[i] = wr_en && (addr == CTRL_PORT) && (sel == 2'(i)) && (cw_fmt == FMT_SNAP);
            dat_wr[i]  = wr_en && (addr == ADDR_W'(i));
        end
    end
endmodule

// File: rtl/tmr_chan.sv
// One channel's register slice.
// Holds mode, BCD flag and access pattern, assembles written bytes into an
// initial count, holds a snapshot of the count, and sequences byte reads.
// Assumes that a programming stroke and a data stroke never come in the same cycle.
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_cfg,
    input  logic              cw_snap,
    input  fmt_e              cw_fmt,
    input  logic [MODE_W-1:0] cw_mode,
    input  logic              cw_bcd,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_stb,
    output logic [BYTE_W-1:0] rd_byte
);
    fmt_e              fmt_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic              snap_v_q;
    logic [CNT_W-1:0]  snap_q;
    logic [BYTE_W-1:0] stage_q;
    logic [CNT_W-1:0]  src;
    logic              rd_hi;
    logic              rd_last;

    // Read byte selection from the snapshot or the live count
    always_comb begin
        src     = snap_v_q ? snap_q : live;
        rd_hi   = (fmt_q == FMT_HI) || ((fmt_q == FMT_BOTH) && rd_hi_q);
        rd_last = (fmt_q != FMT_BOTH) || rd_hi_q;
        rd_byte = rd_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
    end

    // Configuration, snapshot and read-order state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q    <= FMT_BOTH;
            mode     <= '0;
            bcd      <= 1'b0;
            rd_hi_q  <= 1'b0;
            snap_v_q <= 1'b0;
            snap_q   <= '0;
        end else if (cw_cfg) begin
            fmt_q    <= cw_fmt;
            mode     <= cw_mode;
            bcd      <= cw_bcd;
            rd_hi_q  <= 1'b0;
            snap_v_q <= 1'b0;
        end else begin
            if (cw_snap && !snap_v_q) begin
                snap_v_q <= 1'b1;
                snap_q   <= live;
            end
            if (dat_rd) begin
                if (fmt_q == FMT_BOTH) rd_hi_q <= !rd_hi_q;
                if (rd_last) snap_v_q <= 1'b0;
            end
        end
    end

    // Write assembly and load pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hi_q  <= 1'b0;
            stage_q  <= '0;
            load_val <= '0;
            load_stb <= 1'b0;
        end else begin
            load_stb <= 1'b0;
            if (cw_cfg) begin
                wr_hi_q <= 1'b0;
            end else if (dat_wr) begin
                unique case (fmt_q)
                    FMT_LO: begin
                        load_val <= {{(CNT_W-BYTE_W){1'b0}}, wdata};
                        load_stb <= 1'b1;
                    end
                    FMT_HI: begin
                        load_val <= {wdata, {(CNT_W-BYTE_W){1'b0}}};
                        load_stb <= 1'b1;
                    end
                    FMT_BOTH: begin
                        if (!wr_hi_q) begin
                            stage_q <= wdata;
                            wr_hi_q <= 1'b1;
                        end else begin
                            load_val <= {wdata, stage_q};
                            load_stb <= 1'b1;
                            wr_hi_q  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_host_if.sv
// Top of the timer host register front end.
// Decodes host accesses, instantiates one register slice per channel, and
// multiplexes the read byte. Assumes at most one of wr_en / rd_en per cycle.
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTE_W-1:0]       wdata,
    input  logic                    wr_en,
    input  logic                    rd_en,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NCH*CNT_W-1:0]    live_cnt,
    output logic [NCH*CNT_W-1:0]    load_val,
    output logic [NCH-1:0]          load_stb,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH-1:0]          ch_bcd
);
    logic [NCH-1:0]    cw_cfg;
    logic [NCH-1:0]    cw_snap;
    logic [NCH-1:0]    dat_wr;
    logic [NCH-1:0]    dat_rd;
    fmt_e              cw_fmt;
    logic [MODE_W-1:0] cw_mode;
    logic              cw_bcd;
    logic [BYTE_W-1:0] rd_byte [NCH];

    tmr_cw_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .cw_cfg  (cw_cfg),
        .cw_snap (cw_snap),
        .dat_wr  (dat_wr),
        .cw_fmt  (cw_fmt),
        .cw_mode (cw_mode),
        .cw_bcd  (cw_bcd)
    );

    // Per-channel read strokes
    always_comb begin
        for (int i = 0; i < NCH; i++) dat_rd[i] = rd_en && (addr == ADDR_W'(i));
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cw_cfg   (cw_cfg[g]),
            .cw_snap  (cw_snap[g]),
            .cw_fmt   (cw_fmt),
            .cw_mode  (cw_mode),
            .cw_bcd   (cw_bcd),
            .dat_wr   (dat_wr[g]),
            .dat_rd   (dat_rd[g]),
            .wdata    (wdata),
            .live     (live_cnt[g*CNT_W +: CNT_W]),
            .mode     (ch_mode[g*MODE_W +: MODE_W]),
            .bcd      (ch_bcd[g]),
            .load_val (load_val[g*CNT_W +: CNT_W]),
            .load_stb (load_stb[g]),
            .rd_byte  (rd_byte[g])
        );
    end

    // Read data multiplexer, zero when idle or on the control port
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (dat_rd[i]) rdata = rd_byte[i];
        end
    end
endmodule

// File: rtl/tmr_host_if_chk.sv
// Property checker for tmr_host_if, attached by the bind at the end of this file.
module tmr_host_if_chk
    import tmr_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic [BYTE_W-1:0]     wdata,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [BYTE_W-1:0]     rdata,
    input logic [NCH*CNT_W-1:0]  live_cnt,
    input logic [NCH*CNT_W-1:0]  load_val,
    input logic [NCH-1:0]        load_stb,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        ch_bcd
);
    localparam logic [ADDR_W-1:0] CTRL_PORT = ADDR_W'(NCH);

    // R3
    sel_unused_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == CTRL_PORT && wdata[7:6] == 2'b11) |-> ($stable(ch_mode) && $stable(ch_bcd)));

    // R2
    cfg_from_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ch_mode) || !$stable(ch_bcd)) |-> $past(wr_en && addr == CTRL_PORT));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R4
        load_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_stb[g] |-> $past(wr_en && addr == ADDR_W'(g)));

        // R6
        load_val_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(load_val[g*CNT_W +: CNT_W]) |-> load_stb[g]);

        // R2
        mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_mode[g*MODE_W +: MODE_W] <= 3'd5);
    end
endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .live_cnt (live_cnt),
    .load_val (load_val),
    .load_stb (load_stb),
    .ch_mode  (ch_mode),
    .ch_bcd   (ch_bcd)
);

// File: tb/tb_tmr_host_if.sv
module tb_tmr_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt = '0;
    logic [47:0] load_val;
    logic [2:0]  load_stb;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr_host_if dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .live_cnt(live_cnt), .load_val(load_val),
        .load_stb(load_stb), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
    );

    // Table entry: {op(2): 1 write, 2 read-check; addr(2); data(8); expected(8)}
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {2'd1, 2'd3, 8'h34, 8'h00},  // ch0 two-byte, mode 2
        {2'd2, 2'd0, 8'h00, 8'h34},  // R11 low byte first
        {2'd2, 2'd0, 8'h00, 8'h12},  // R11 then high byte
        {2'd1, 2'd3, 8'h50, 8'h00},  // ch1 low only
        {2'd2, 2'd1, 8'h00, 8'hCD},  // R11
        {2'd2, 2'd1, 8'h00, 8'hCD},  // R11 low again
        {2'd1, 2'd3, 8'hA0, 8'h00},  // ch2 high only
        {2'd2, 2'd2, 8'h00, 8'h0F},  // R11
        {2'd2, 2'd3, 8'h00, 8'h00}   // R12 control port reads zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, 32'(rdata), 32'(exp));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        live_cnt = {16'h0F0F, 16'hABCD, 16'h1234};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", 32'(ch_mode), 0);
        check("R1 bcd", 32'(ch_bcd), 0);
        check("R1 stb", 32'(load_stb), 0);
        check("R1 load", 32'(load_val[31:0]), 0);
        check("R1 rdata idle", 32'(rdata), 0);
        rd(2'd2, 8'h0F, "R1 two-byte low");
        rd(2'd2, 8'h0F, "R1 two-byte high");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19:18] == 2'd1) wr(VEC[i][17:16], VEC[i][15:8]);
            else rd(VEC[i][17:16], VEC[i][7:0], $sformatf("table step %0d", i));
        end

        // R2 decode to the selected channel only
        wr(2'd3, 8'h7B);
        check("R2 ch1 mode", 32'(ch_mode[5:3]), 5);
        check("R2 ch1 bcd", 32'(ch_bcd[1]), 1);
        check("R2 ch0 untouched", 32'(ch_mode[2:0]), 2);
        wr(2'd3, 8'h9C);
        check("R2 mode fold", 32'(ch_mode[8:6]), 2);

        // R3 select 11 ignored
        wr(2'd3, 8'hFE);
        check("R3 modes", 32'(ch_mode), {3'd2, 3'd5, 3'd2});
        check("R3 bcd", 32'(ch_bcd), 3'b010);

        // R4 low-only write
        wr(2'd2, 8'h5A);
        check("R4 stb", 32'(load_stb), 3'b100);
        check("R4 value", 32'(load_val[47:32]), 16'h005A);
        @(negedge clk);
        check("R4 stb one cycle", 32'(load_stb), 0);

        // R5 high-only write
        wr(2'd3, 8'hA0);
        wr(2'd2, 8'h77);
        check("R5 stb", 32'(load_stb), 3'b100);
        check("R5 value", 32'(load_val[47:32]), 16'h7700);

        // R6 two-byte write
        wr(2'd0, 8'h11);
        check("R6 no stb first", 32'(load_stb), 0);
        check("R6 value held", 32'(load_val[15:0]), 0);
        wr(2'd0, 8'h22);
        check("R6 stb second", 32'(load_stb), 3'b001);
        check("R6 value", 32'(load_val[15:0]), 16'h2211);

        // R7 snapshot, R8 second capture ignored
        wr(2'd3, 8'h00);
        live_cnt[15:0] = 16'h9999;
        wr(2'd3, 8'h00);
        check("R7 mode kept", 32'(ch_mode[2:0]), 2);
        rd(2'd0, 8'h34, "R7/R8 snapshot low");
        rd(2'd0, 8'h12, "R7/R8 snapshot high");
        // R9 back to live
        rd(2'd0, 8'h99, "R9 live low");
        rd(2'd0, 8'h99, "R9 live high");

        // R10 control word resets order and drops snapshot
        wr(2'd3, 8'h00);
        live_cnt[15:0] = 16'h4321;
        rd(2'd0, 8'h99, "R10 snapshot low");
        wr(2'd3, 8'h34);
        rd(2'd0, 8'h21, "R10 live low after cw");
        rd(2'd0, 8'h43, "R10 live high");

        // R12 idle read bus
        @(negedge clk);
        addr = 2'd0;
        #1;
        check("R12 rd_en low", 32'(rdata), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule